// File: doc/BRIEF.md
# Packed FP32 Horizontal Pair Adder

This unit takes two 256-bit vectors of IEEE-754 single-precision elements and adds neighbouring elements of the same source. Each 128-bit lane of the result gets two sums from the first source in its low half and two sums from the second source in its high half. One binary32 adder is shared across all the sums. It works one pair per clock, and a start/done handshake frames each operation.

A two-bit mode input picks how the upper 128 bits are produced. In merge mode they are copied from a prior-destination input. In clear mode they are zeroed. In wide mode they are computed from the upper lanes of both sources. Five sticky exception flags are gathered over every sum computed in the operation. Only round-to-nearest-even is supported.

Top module: `hpair_add`

## Requirements
- R1: Within lane 0, result element 0 (bits 31:0) is source1 element 1 plus element 0, and result element 1 (bits 63:32) is source1 element 3 plus element 2.
- R2: Within lane 0, result element 2 (bits 95:64) is source2 element 1 plus element 0, and result element 3 (bits 127:96) is source2 element 3 plus element 2.
- R3: When mode bit 1 is set (mode 2 or 3), bits 255:128 follow the same pattern on the upper lane: elements 4 and 5 of the result come from source1 pairs (5,4) and (7,6), and elements 6 and 7 come from source2 pairs (5,4) and (7,6).
- R4: In mode 0 (merge), result bits 255:128 equal the prior-destination input captured when start was accepted.
- R5: In mode 1 (clear), result bits 255:128 are zero.
- R6: Each sum is a binary32 add rounded to nearest, ties to even, with subnormal operands and results handled exactly. An exact zero sum of operands with opposite signs is +0, and the sum of two -0 is -0.
- R7: Any NaN operand gives 0x7FC00000. Infinity plus an opposite-signed infinity also gives 0x7FC00000 and raises invalid. A signalling NaN operand (exponent all ones, fraction nonzero, fraction bit 22 clear) raises invalid, but a quiet NaN alone does not. An infinity added to a finite value returns that infinity.
- R8: A rounded magnitude beyond the largest finite value gives a correctly signed infinity and raises overflow and inexact.
- R9: Denormal is raised whenever either addend is subnormal. Underflow is raised only when the result is tiny before rounding and also inexact, so an exact subnormal sum raises no underflow.
- R10: flags_o bit 0 is invalid, bit 1 denormal, bit 2 overflow, bit 3 underflow and bit 4 inexact. The flags are the OR over all pairs of the operation and are cleared when start is accepted.
- R11: After reset busy_o, done_o, res_o and flags_o are zero. done_o rises for exactly one cycle on the 4th clock edge after the edge that accepts start in modes 0 and 1, and on the 8th in modes 2 and 3. busy_o is high from the accepting edge until done_o rises.
- R12: Start is ignored while busy_o is high. res_o and flags_o do not change between done_o and the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation when idle |
| mode_i | input | 2 | 0 merge upper half, 1 clear upper half, 2/3 wide |
| src1_i | input | 256 | First source vector, eight binary32 elements |
| src2_i | input | 256 | Second source vector |
| dprev_i | input | 256 | Prior destination value, upper half used in merge mode |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_o | output | 256 | Result vector |
| flags_o | output | 5 | Sticky exception flags |

## Verification
A result and its flags are due together with done_o, on the 4th or 8th rising edge after the edge that samples start, depending on mode. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the start pulse and requires done_o to appear on the 5th or 9th, then reads the result and flags in that same half cycle. For the busy-ignore and hold checks, the bench watches a fixed window of later falling edges and requires res_o to stay unchanged and done_o to stay low throughout.

// File: rtl/hpa_pkg.sv
package hpa_pkg;
    localparam int EW = 32;

    typedef enum logic [1:0] {
        MODE_KEEP  = 2'd0,
        MODE_CLEAR = 2'd1,
        MODE_WIDE  = 2'd2,
        MODE_WIDE2 = 2'd3
    } hpa_mode_e;

    // packed: invalid sits in bit 0, inexact in bit 4
    typedef struct packed {
        logic inexact;
        logic underflow;
        logic overflow;
        logic denormal;
        logic invalid;
    } hpa_flags_t;

    localparam logic [EW-1:0] QNAN_CANON = 32'h7FC0_0000;
endpackage

// File: rtl/hpa_pair_sel.sv
module hpa_pair_sel
    import hpa_pkg::*;
#(
    parameter int LANES = 2,
    parameter int IW    = 3
) (
    input  logic [LANES*128-1:0] s1_i,
    input  logic [LANES*128-1:0] s2_i,
    input  logic [IW-1:0]        idx_i,
    output logic [EW-1:0]        a_o,
    output logic [EW-1:0]        b_o
);
    localparam int LANE_EL = 128 / EW;
    localparam int NE      = LANES * LANE_EL;

    logic [EW-1:0] s1_e [NE];
    logic [EW-1:0] s2_e [NE];

    for (genvar e = 0; e < NE; e++) begin : g_el
        assign s1_e[e] = s1_i[e*EW +: EW];
        assign s2_e[e] = s2_i[e*EW +: EW];
    end

    int slot, lane, base;

    always_comb begin
        slot = int'(idx_i) % LANE_EL;
        lane = int'(idx_i) / LANE_EL;
        base = lane * LANE_EL + 2 * (slot % 2);
        if (slot >= 2) begin
            a_o = s2_e[base + 1];
            b_o = s2_e[base];
        end else begin
            a_o = s1_e[base + 1];
            b_o = s1_e[base];
        end
    end
endmodule

// File: rtl/hpa_fp32_add.sv
module hpa_fp32_add
    import hpa_pkg::*;
(
    input  logic [EW-1:0] a_i,
    input  logic [EW-1:0] b_i,
    output logic [EW-1:0] sum_o,
    output hpa_flags_t    flg_o
);
    localparam int MW = 24;
    localparam int GW = 3;
    localparam int XW = MW + GW;

    logic          a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_sub, b_sub;
    logic          swap, sub_op, sticky, found, tiny;
    logic          grd, rbit, stk, lsb, rnd, inx, ovf;
    logic [EW-1:0] big, sml;
    logic [9:0]    e_big, e_sml, d, e_norm, shamt, exp_f;
    logic [XW-1:0] m_big, m_sml_full, m_sml_sh, m_sml_st, norm;
    logic [XW:0]   acc;
    logic [4:0]    lz;
    logic [32:0]   packed_v;

    always_comb begin
        a_inf  = (&a_i[30:23]) && (a_i[22:0] == 23'd0);
        b_inf  = (&b_i[30:23]) && (b_i[22:0] == 23'd0);
        a_nan  = (&a_i[30:23]) && (|a_i[22:0]);
        b_nan  = (&b_i[30:23]) && (|b_i[22:0]);
        a_snan = a_nan && !a_i[22];
        b_snan = b_nan && !b_i[22];
        a_sub  = (a_i[30:23] == 8'd0) && (|a_i[22:0]);
        b_sub  = (b_i[30:23] == 8'd0) && (|b_i[22:0]);

        // order by magnitude so the subtraction never goes negative
        swap   = b_i[30:0] > a_i[30:0];
        big    = swap ? b_i : a_i;
        sml    = swap ? a_i : b_i;
        sub_op = big[31] ^ sml[31];

        e_big = (big[30:23] == 8'd0) ? 10'd1 : {2'b00, big[30:23]};
        e_sml = (sml[30:23] == 8'd0) ? 10'd1 : {2'b00, sml[30:23]};
        m_big      = {big[30:23] != 8'd0, big[22:0], 3'b000};
        m_sml_full = {sml[30:23] != 8'd0, sml[22:0], 3'b000};

        d        = e_big - e_sml;
        m_sml_sh = m_sml_full >> d;
        sticky   = ((m_sml_sh << d) != m_sml_full);
        m_sml_st = m_sml_sh | {{(XW-1){1'b0}}, sticky};

        acc = sub_op ? ({1'b0, m_big} - {1'b0, m_sml_st})
                     : ({1'b0, m_big} + {1'b0, m_sml_st});

        lz    = 5'(XW);
        found = 1'b0;
        for (int i = XW - 1; i >= 0; i--) begin
            if (!found && acc[i]) begin
                lz    = 5'(XW - 1 - i);
                found = 1'b1;
            end
        end

        if (acc[XW]) begin
            shamt  = 10'd0;
            norm   = acc[XW:1] | {{(XW-1){1'b0}}, acc[0]};
            e_norm = e_big + 10'd1;
        end else begin
            // never shift below the smallest normal exponent
            shamt  = ({5'b0, lz} < (e_big - 10'd1)) ? {5'b0, lz} : (e_big - 10'd1);
            norm   = acc[XW-1:0] << shamt;
            e_norm = e_big - shamt;
        end

        tiny  = !norm[XW-1];
        exp_f = tiny ? 10'd0 : e_norm;
        grd   = norm[2];
        rbit  = norm[1];
        stk   = norm[0];
        lsb   = norm[3];
        rnd   = grd & (rbit | stk | lsb);
        inx   = grd | rbit | stk;

        // a carry out of the fraction bumps the exponent field for free
        packed_v = {exp_f, norm[XW-2:GW]} + {32'd0, rnd};
        ovf      = packed_v[32:23] >= 10'd255;

        flg_o          = '0;
        flg_o.denormal = a_sub | b_sub;
        if (a_nan || b_nan) begin
            sum_o         = QNAN_CANON;
            flg_o.invalid = a_snan | b_snan;
        end else if (a_inf && b_inf && (a_i[31] ^ b_i[31])) begin
            sum_o         = QNAN_CANON;
            flg_o.invalid = 1'b1;
        end else if (a_inf || b_inf) begin
            sum_o = a_inf ? a_i : b_i;
        end else if (acc == '0) begin
            sum_o = {sub_op ? 1'b0 : big[31], 31'd0};
        end else if (ovf) begin
            sum_o          = {big[31], 8'hFF, 23'd0};
            flg_o.overflow = 1'b1;
            flg_o.inexact  = 1'b1;
        end else begin
            sum_o           = {big[31], packed_v[30:0]};
            flg_o.inexact   = inx;
            flg_o.underflow = tiny & inx;
        end
    end
endmodule

// File: rtl/hpair_add.sv
module hpair_add
    import hpa_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [1:0]           mode_i,
    input  logic [LANES*128-1:0] src1_i,
    input  logic [LANES*128-1:0] src2_i,
    input  logic [LANES*128-1:0] dprev_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [LANES*128-1:0] res_o,
    output logic [4:0]           flags_o
);
    localparam int VW      = LANES * 128;
    localparam int LANE_EL = 128 / EW;
    localparam int NE      = LANES * LANE_EL;
    localparam int IW      = $clog2(NE);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [IW-1:0] idx;
        logic [IW-1:0] last;
        logic [VW-1:0] s1;
        logic [VW-1:0] s2;
        logic [VW-1:0] res;
        hpa_flags_t    flg;
    } st_t;

    st_t           st_d, st_q;
    logic [EW-1:0] pa, pb, psum;
    hpa_flags_t    pflg;

    hpa_pair_sel #(.LANES(LANES), .IW(IW)) u_sel (
        .s1_i  (st_q.s1),
        .s2_i  (st_q.s2),
        .idx_i (st_q.idx),
        .a_o   (pa),
        .b_o   (pb)
    );

    hpa_fp32_add u_add (
        .a_i   (pa),
        .b_i   (pb),
        .sum_o (psum),
        .flg_o (pflg)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy && start_i) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.last = mode_i[1] ? IW'(NE - 1) : IW'(LANE_EL - 1);
            st_d.s1   = src1_i;
            st_d.s2   = src2_i;
            st_d.flg  = '0;
            // lane 0 is overwritten pair by pair; upper part is final here
            st_d.res  = (mode_i == MODE_KEEP) ? dprev_i : '0;
        end else if (st_q.busy) begin
            // pair index equals destination element index
            st_d.res[int'(st_q.idx)*EW +: EW] = psum;
            st_d.flg = hpa_flags_t'(st_q.flg | pflg);
            st_d.idx = st_q.idx + 1'b1;
            if (st_q.idx == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o  = st_q.busy;
    assign done_o  = st_q.done;
    assign res_o   = st_q.res;
    assign flags_o = st_q.flg;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R12
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(res_o) && $stable(flags_o)));

    // R7
    nan_on_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && pflg.invalid) |-> (psum == QNAN_CANON));

    // R8
    inf_on_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && pflg.overflow) |-> (psum[30:0] == 31'h7F80_0000));
endmodule

// File: tb/hpair_add_bench.sv
`timescale 1ns/1ps
module hpair_add_bench;
    localparam int VW = 256;
    localparam logic [31:0] ONE  = 32'h3F80_0000;
    localparam logic [31:0] TWO  = 32'h4000_0000;
    localparam logic [31:0] FOUR = 32'h4080_0000;

    // {a (upper element), b (lower element), expected sum, expected flags}
    localparam logic [127:0] TBL [16] = '{
        {32'h3F800000, 32'h40000000, 32'h40400000, 32'h00},
        {32'h3FC00000, 32'hBE800000, 32'h3FA00000, 32'h00},
        {32'h3F800000, 32'h33800000, 32'h3F800000, 32'h10},
        {32'h3F800001, 32'h33800000, 32'h3F800002, 32'h10},
        {32'h7F800000, 32'hFF800000, 32'h7FC00000, 32'h01},
        {32'h7F800001, 32'h3F800000, 32'h7FC00000, 32'h01},
        {32'h7FC00000, 32'h3F800000, 32'h7FC00000, 32'h00},
        {32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 32'h14},
        {32'h3F800000, 32'hBF800000, 32'h00000000, 32'h00},
        {32'h80000000, 32'h80000000, 32'h80000000, 32'h00},
        {32'h00000001, 32'h00000001, 32'h00000002, 32'h02},
        {32'h3F800000, 32'h00000001, 32'h3F800000, 32'h12},
        {32'h00800000, 32'h80000001, 32'h007FFFFF, 32'h02},
        {32'hFF800000, 32'h3F800000, 32'hFF800000, 32'h00},
        {32'h4B800000, 32'h3F800000, 32'h4B800000, 32'h10},
        {32'hC0400000, 32'h3F800000, 32'hC0000000, 32'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [VW-1:0] src1 = '0, src2 = '0, dprev = '0;
    logic          busy, done;
    logic [VW-1:0] res;
    logic [4:0]    flags;

    int total = 0;
    int bad   = 0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    hpair_add u_hpair_add (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .mode_i  (mode),
        .src1_i  (src1),
        .src2_i  (src2),
        .dprev_i (dprev),
        .busy_o  (busy),
        .done_o  (done),
        .res_o   (res),
        .flags_o (flags)
    );

    function automatic string row_tag(int r);
        case (r)
            4, 5, 6, 13:    return "R7";
            7:              return "R8";
            10, 11, 12:     return "R9";
            default:        return "R6";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [VW-1:0] act, logic [VW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] m, input logic [VW-1:0] a1,
                          input logic [VW-1:0] a2, input logic [VW-1:0] dp,
                          output int lat);
        @(negedge clk);
        mode = m; src1 = a1; src2 = a2; dprev = dp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL R11 watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [VW-1:0] s1v, s2v, expv, lane0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "reset busy/done", {254'd0, busy, done}, '0);
        chk("R11", "reset result", res, '0);
        chk("R11", "reset flags", {251'd0, flags}, '0);

        // table walk: each row in one pair position, all other pairs 0+0
        for (int r = 0; r < 16; r++) begin
            int p, ln, sl, base;
            string ptag;
            p = r % 8; ln = p / 4; sl = p % 4;
            base = ln * 4 + 2 * (sl % 2);
            s1v = '0; s2v = '0; expv = '0;
            if (sl < 2) begin
                s1v[(base+1)*32 +: 32] = TBL[r][127:96];
                s1v[base*32 +: 32]     = TBL[r][95:64];
            end else begin
                s2v[(base+1)*32 +: 32] = TBL[r][127:96];
                s2v[base*32 +: 32]     = TBL[r][95:64];
            end
            expv[(ln*4+sl)*32 +: 32] = TBL[r][63:32];
            ptag = (ln == 1) ? "R3" : ((sl < 2) ? "R1" : "R2");
            run_op(2'd2, s1v, s2v, '1, lat);
            chk(row_tag(r), $sformatf("row %0d sum", r), {224'd0, res[(ln*4+sl)*32 +: 32]},
                {224'd0, TBL[r][63:32]});
            chk(ptag, $sformatf("row %0d placement", r), res, expv);
            chk("R10", $sformatf("row %0d flags", r), {251'd0, flags}, {251'd0, TBL[r][4:0]});
        end

        lane0 = {128'd0, FOUR, FOUR, TWO, TWO};

        // R4 merge mode and short latency (R11)
        run_op(2'd0, {8{ONE}}, {8{TWO}}, {{4{32'hDEADBEEF}}, {4{32'h12345678}}}, lat);
        chk("R11", "latency merge", VW'(lat), VW'(5));
        chk("R4", "merge upper", res, {{4{32'hDEADBEEF}}, lane0[127:0]});

        // R5 clear mode
        run_op(2'd1, {8{ONE}}, {8{TWO}}, {8{32'hA5A5A5A5}}, lat);
        chk("R11", "latency clear", VW'(lat), VW'(5));
        chk("R5", "clear upper", res, lane0);

        // R3 wide modes
        run_op(2'd2, {8{ONE}}, {8{TWO}}, {8{32'hA5A5A5A5}}, lat);
        chk("R11", "latency wide", VW'(lat), VW'(9));
        chk("R3", "wide mode 2", res, {2{lane0[127:0]}});
        run_op(2'd3, {8{ONE}}, {8{TWO}}, {8{32'hA5A5A5A5}}, lat);
        chk("R3", "wide mode 3", res, {2{lane0[127:0]}});

        // R10 flags OR over pairs: inf-inf at pair 0, 1+tiny at pair 6
        s1v = '0; s2v = '0; expv = '0;
        s1v[63:0]    = {32'h7F800000, 32'hFF800000};
        s2v[191:128] = {ONE, 32'h00000001};
        expv[31:0]    = 32'h7FC00000;
        expv[223:192] = ONE;
        run_op(2'd2, s1v, s2v, '0, lat);
        chk("R10", "or result", res, expv);
        chk("R10", "or flags", {251'd0, flags}, {251'd0, 5'h13});
        run_op(2'd2, {8{ONE}}, {8{TWO}}, '0, lat);
        chk("R10", "flags cleared on start", {251'd0, flags}, '0);

        // R12 start ignored while busy, then outputs hold
        @(negedge clk);
        mode = 2'd1; src1 = {8{32'h3F000000}}; src2 = {8{ONE}}; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        mode = 2'd0; src1 = {8{TWO}}; src2 = {8{TWO}}; dprev = {8{32'h11111111}}; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 3;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk("R12", "busy start latency", VW'(lat), VW'(5));
        chk("R12", "busy start ignored", res, {128'd0, TWO, TWO, ONE, ONE});
        begin
            int extra;
            extra = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (done) extra++;
                chk("R12", "result holds", res, {128'd0, TWO, TWO, ONE, ONE});
            end
            chk("R12", "no extra done", VW'(extra), '0);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule